// File: doc/BRIEF.md
# Bernoulli Stream Stochastic Multiplier

This block estimates the product of two 4-bit unsigned operands, each taken as a probability equal to its value over 16. It does not build partial products. On every enabled clock, two 8-bit maximal-length shift registers each produce a 4-bit random threshold. The registers share one feedback polynomial but start from different seeds, so their sequences are offset in phase. Each operand is compared with its own threshold. The AND of the two comparison results is a stream bit that is 1 with probability (A/16)·(B/16).

A 16-bit counter adds up the stream bits, and its low byte appears on the output. After W enabled cycles, the count divided by W estimates the product. That division happens outside the block. Raising W lowers the variance of the estimate.

Top module: `bern_mult`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counter clears to 0 and the two shift registers reload their seeds, 8'h01 for A and 8'hA5 for B. This happens whatever the value of `en`.
- R2: On each enabled cycle, each shift register steps from state s to {s[6:0], s[7]^s[5]^s[4]^s[3]}. This is the polynomial x^8+x^6+x^5+x^4+1. The 4-bit threshold is s[3:0] of the state before the step.
- R3: A comparison fires when its threshold is strictly less than its operand. An operand of 0 therefore never fires, and the count does not change while either operand is 0.
- R4: On an enabled cycle, the counter rises by exactly 1 when both comparisons fire and stays unchanged otherwise. The result is visible on `count_lo` after that rising edge.
- R5: While `en` is low, the counter and both shift registers hold their values. When `en` returns high, the random sequence continues from where it stopped.
- R6: `count_lo` carries bits [7:0] of the 16-bit counter. The counter wraps modulo 2^16, so the output byte wraps modulo 256.
- R7: With A=8 and B=8, 256 enabled cycles from reset give a count close to the true product of 64, within 48 to 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Block selected; the registers and the counter advance only while high |
| op_a | input | 4 | Operand A, read as op_a/16 |
| op_b | input | 4 | Operand B, read as op_b/16 |
| count_lo | output | 8 | Low byte of the coincidence counter |

## Verification
The assertions assume that `rst_n` is asserted low at least once before `en` is used. They also assume that `en`, `op_a` and `op_b` are stable around each rising edge, so that the threshold comparison seen at an edge belongs to that cycle's operands. The stimulus meets these assumptions. Reset is held for four cycles at the start, and again in the middle of the run. All inputs change only on falling edges. The bench keeps its own model of the two shift registers, stepped from the seeds and taps given in the requirements. With that model it predicts the exact count for every cycle, across held operands, zero operands, idle stretches and long runs in which the output byte wraps.

// File: rtl/bern_mult.sv
`timescale 1ns/1ps
module bern_mult #(
  parameter int          OP_W   = 4,
  parameter int          SR_W   = 8,
  parameter int          CNT_W  = 16,
  parameter int          OUT_W  = 8,
  parameter logic [7:0]  SEED_A = 8'h01,
  parameter logic [7:0]  SEED_B = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic [OUT_W-1:0] count_lo
);

  logic [SR_W-1:0]  sr_a, sr_b;
  logic [CNT_W-1:0] cnt;
  logic             fire_a, fire_b, hit;

  function automatic logic [SR_W-1:0] sr_next(input logic [SR_W-1:0] s);
    return {s[SR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  assign fire_a   = sr_a[OP_W-1:0] < op_a;
  assign fire_b   = sr_b[OP_W-1:0] < op_b;
  assign hit      = fire_a & fire_b;
  assign count_lo = cnt[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_a <= SEED_A;
      sr_b <= SEED_B;
      cnt  <= '0;
    end else if (en) begin
      sr_a <= sr_next(sr_a);
      sr_b <= sr_next(sr_b);
      cnt  <= cnt + CNT_W'(hit);
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0 && sr_a == SEED_A && sr_b == SEED_B));

  p_sr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sr_a != '0 && sr_b != '0));

  p_zero_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_a == '0 || op_b == '0)) |=> $stable(cnt));

  p_no_hit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit) |=> $stable(cnt));

  p_hit_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit) |=> (cnt != $past(cnt)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && $stable(sr_a) && $stable(sr_b)));

  p_out_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit) |=> (count_lo == OUT_W'($past(count_lo) + 1'b1)));

endmodule

// File: tb/tb_bern_mult.sv
`timescale 1ns/1ps
module tb_bern_mult;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] op_a = '0, op_b = '0;
  logic [7:0] count_lo;

  int    n_checks = 0, n_errors = 0;
  bit    finished = 0;
  item_t sb[$];

  logic [7:0]  ma, mb;
  logic [15:0] mcnt;

  always #4 clk = ~clk;

  bern_mult dut (.clk(clk), .rst_n(rst_n), .en(en), .op_a(op_a), .op_b(op_b), .count_lo(count_lo));

  function automatic logic [7:0] step_sr(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit r, input bit e, input logic [3:0] a, input logic [3:0] b, input string tag);
    item_t it;
    @(negedge clk);
    rst_n = r; en = e; op_a = a; op_b = b;
    if (!r) begin
      ma = 8'h01; mb = 8'hA5; mcnt = '0;
    end else if (e) begin
      if ((ma[3:0] < a) && (mb[3:0] < b)) mcnt = mcnt + 16'd1;
      ma = step_sr(ma);
      mb = step_sr(mb);
    end
    it.exp = mcnt[7:0];
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, count_lo, it.exp);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    ma = 8'h01; mb = 8'hA5; mcnt = '0;
    for (int i = 0; i < 4; i++) drive(0, 1, 4'd15, 4'd15, "R1 reset");
    for (int i = 0; i < 255; i++) drive(1, 1, 4'd15, 4'd15, "R2 R4 full period");
    for (int i = 0; i < 60; i++) drive(1, 1, 4'd0, 4'd15, "R3 zero A");
    for (int i = 0; i < 60; i++) drive(1, 1, 4'd9, 4'd0, "R3 zero B");
    for (int i = 0; i < 40; i++) drive(1, 1, 4'd5, 4'd11, "R4 mixed");
    for (int i = 0; i < 25; i++) drive(1, 0, 4'd15, 4'd15, "R5 idle hold");
    for (int i = 0; i < 80; i++) drive(1, 1, 4'd13, 4'd7, "R5 resume");
    for (int i = 0; i < 400; i++) drive(1, 1, 4'd15, 4'd15, "R6 byte wrap");
    for (int i = 0; i < 4; i++) drive(0, 0, 4'd3, 4'd3, "R1 reset while idle");
    for (int i = 0; i < 256; i++) drive(1, 1, 4'd8, 4'd8, "R7 half by half");
    @(posedge clk); #3;
    n_checks++;
    if (count_lo < 8'd48 || count_lo > 8'd80) begin
      n_errors++;
      $display("FAIL R7 estimate: actual=%0d expected=48..80", count_lo);
    end
    for (int i = 0; i < 4; i++) drive(0, 1, 4'd1, 4'd1, "R1 reset again");
    for (int i = 0; i < 100; i++) drive(1, 1, 4'd1, 4'd15, "R3 low operand");
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end

endmodule